// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words in the common single-precision encoding. The sign sits in bit 31, the biased exponent in bits 30..23 and the stored fraction in bits 22..0. A normal operand has an exponent field E in 1..254 and stands for (-1)^S × (1.F) × 2^(E-127). The block restores the hidden one on both significands and forms the full 48-bit product. It adds the exponents and removes one bias, then normalizes, rounds to nearest with ties to even, and packs the result.

Operands with special encodings are handled before the arithmetic. An exponent field of zero counts as zero, so subnormal inputs are flushed to zero. An all-ones exponent with a zero fraction is infinity, and an all-ones exponent with a nonzero fraction is a NaN. A result that leaves the normal exponent range raises a flag and is replaced by a signed infinity or a signed zero.

The block is a two-stage pipeline. It takes a new operand pair on any cycle where `in_valid` is high and delivers each result two clock edges later, with its own valid bit and three status flags.

Top module: `fp32_mul`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid, result and all three flags are 0.
- R2: A pair sampled with in_valid high at one rising edge appears on the outputs after the second rising edge that follows. Results come out one per cycle, in issue order. When no pair was issued, out_valid is 0 and result and flags are 0.
- R3: For two normal operands, the result sign is the XOR of the two sign bits (bit 31). The result biased exponent (bits 30..23) is the sum of the two exponent fields minus 127, and the fraction (bits 22..0) comes from the product of the two 24-bit significands with the hidden one restored.
- R4: If the significand product is 2 or more, it is shifted right by one place and the exponent is incremented by one.
- R5: Rounding is to nearest with ties to even. It uses the guard bit, the round bit and a sticky OR of all lower product bits. An exact half rounds up only when the kept fraction LSB is 1.
- R6: If the rounding increment carries out of the fraction, the fraction becomes zero and the exponent is incremented again.
- R7: If either operand is a NaN (exponent 255, fraction nonzero), or one operand is zero and the other infinity, the result is 0x7FC00000 and flag_nan is 1.
- R8: Infinity (exponent 255, fraction 0) times a nonzero non-NaN operand gives infinity with the XOR sign and no flag set.
- R9: An operand with exponent field 0 is treated as zero, whatever its fraction. Zero times a finite operand gives zero with the XOR sign and no flag set.
- R10: If the final biased exponent is 255 or more, the result is infinity with the XOR sign and flag_ovf is 1.
- R11: If the final biased exponent is 0 or less, the result is zero with the XOR sign and flag_unf is 1.
- R12: At most one of flag_ovf, flag_unf and flag_nan is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The operand pair on op_a and op_b is to be multiplied |
| op_a | input | 32 | First operand, single-precision encoding |
| op_b | input | 32 | Second operand, single-precision encoding |
| out_valid | output | 1 | result and flags hold a finished product |
| result | output | 32 | Packed single-precision product |
| flag_ovf | output | 1 | Exponent overflow; result is signed infinity |
| flag_unf | output | 1 | Exponent underflow; result is signed zero |
| flag_nan | output | 1 | Invalid operation; result is the quiet NaN 0x7FC00000 |

## Verification
The product is exercised with exact products that need no normalization shift, with products of 2 or more that do need it, and with operands chosen so that the guard, round and sticky bits give a round up, a tie that stays even, a tie that rounds to even, and an increment that carries out of the fraction. These show whether the shift, the sticky reduction and the tie rule are each right on their own. Special operands (NaN, zero times infinity, infinity, true zero and subnormal) separate the class priority from the arithmetic. Operands just inside and just outside the exponent range, with both signs, show where the overflow and underflow limits sit and that the sign survives the substitution. A back-to-back stream checks the latency and the ordering.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int BIAS    = EXP_MAX >> 1;
    localparam int XE_W    = EXP_W + 2;

    localparam logic [WORD_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        K_NORM = 2'd0,
        K_ZERO = 2'd1,
        K_INF  = 2'd2,
        K_NAN  = 2'd3
    } kind_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        kind_t             kind;
    } opnd_t;

    typedef struct packed {
        logic                    valid;
        logic                    sign;
        kind_t                   kind;
        logic signed [XE_W-1:0]  exp;
        logic [PROD_W-1:0]       prod;
    } mid_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic nan;
    } flags_t;

    function automatic kind_t classify(input logic [EXP_W-1:0] e,
                                       input logic [FRAC_W-1:0] f);
        if (e == '0)
            return K_ZERO;
        else if (e == {EXP_W{1'b1}})
            return (f == '0) ? K_INF : K_NAN;
        else
            return K_NORM;
    endfunction

    function automatic kind_t merge_kind(input kind_t a, input kind_t b);
        if (a == K_NAN || b == K_NAN)
            return K_NAN;
        else if ((a == K_ZERO && b == K_INF) || (a == K_INF && b == K_ZERO))
            return K_NAN;
        else if (a == K_INF || b == K_INF)
            return K_INF;
        else if (a == K_ZERO || b == K_ZERO)
            return K_ZERO;
        else
            return K_NORM;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic s,
                                                    input logic [EXP_W-1:0] e,
                                                    input logic [FRAC_W-1:0] f);
        return {s, e, f};
    endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output opnd_t             fields
);
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;

    assign e = word[WORD_W-2 -: EXP_W];
    assign f = word[FRAC_W-1:0];

    always_comb begin
        fields.sign = word[WORD_W-1];
        fields.exp  = e;
        fields.kind = classify(e, f);
        fields.sig  = {1'b1, f};
    end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
(
    input  mid_t              mid,
    output logic [WORD_W-1:0] word,
    output flags_t            flags
);
    localparam logic signed [XE_W-1:0] E_TOP = XE_W'(EXP_MAX);

    logic                   hi;
    logic [PROD_W-1:0]      aligned;
    logic [FRAC_W-1:0]      kept;
    logic                   g_bit, r_bit, s_bit, bump;
    logic [FRAC_W:0]        rounded;
    logic signed [XE_W-1:0] e_norm, e_fin;

    always_comb begin
        hi      = mid.prod[PROD_W-1];
        aligned = hi ? mid.prod : (mid.prod << 1);
        kept    = aligned[PROD_W-2 -: FRAC_W];
        g_bit   = aligned[PROD_W-2-FRAC_W];
        r_bit   = aligned[PROD_W-3-FRAC_W];
        s_bit   = |aligned[PROD_W-4-FRAC_W:0];
        bump    = g_bit & (r_bit | s_bit | kept[0]);
        rounded = {1'b0, kept} + {{FRAC_W{1'b0}}, bump};
        e_norm  = mid.exp + $signed({{(XE_W-1){1'b0}}, hi});
        e_fin   = e_norm + $signed({{(XE_W-1){1'b0}}, rounded[FRAC_W]});

        flags = '0;
        word  = '0;
        if (mid.valid) begin
            unique case (mid.kind)
                K_NAN: begin
                    word      = QNAN;
                    flags.nan = 1'b1;
                end
                K_INF:  word = pack_word(mid.sign, {EXP_W{1'b1}}, '0);
                K_ZERO: word = pack_word(mid.sign, '0, '0);
                default: begin
                    if (e_fin >= E_TOP) begin
                        word      = pack_word(mid.sign, {EXP_W{1'b1}}, '0);
                        flags.ovf = 1'b1;
                    end else if (e_fin <= 0) begin
                        word      = pack_word(mid.sign, '0, '0);
                        flags.unf = 1'b1;
                    end else begin
                        word = pack_word(mid.sign, e_fin[EXP_W-1:0],
                                         rounded[FRAC_W-1:0]);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fp32_mul.sv
module fp32_mul
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              flag_ovf,
    output logic              flag_unf,
    output logic              flag_nan
);
    localparam int NOPS = 2;

    logic [WORD_W-1:0] ops [NOPS];
    opnd_t             un  [NOPS];
    mid_t              mid_d, mid_q;
    logic [WORD_W-1:0] word_d;
    flags_t            flags_d;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < NOPS; i++) begin : g_unpack
        fpm_unpack u_unpack (.word(ops[i]), .fields(un[i]));
    end

    always_comb begin
        mid_d.valid = in_valid;
        mid_d.sign  = un[0].sign ^ un[1].sign;
        mid_d.kind  = merge_kind(un[0].kind, un[1].kind);
        mid_d.exp   = $signed({2'b00, un[0].exp}) + $signed({2'b00, un[1].exp})
                      - $signed(XE_W'(BIAS));
        mid_d.prod  = PROD_W'(un[0].sig) * PROD_W'(un[1].sig);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mid_q <= '0;
        else
            mid_q <= mid_d;
    end

    fpm_round u_round (.mid(mid_q), .word(word_d), .flags(flags_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag_ovf  <= 1'b0;
            flag_unf  <= 1'b0;
            flag_nan  <= 1'b0;
        end else begin
            out_valid <= mid_q.valid;
            result    <= word_d;
            flag_ovf  <= flags_d.ovf;
            flag_unf  <= flags_d.unf;
            flag_nan  <= flags_d.nan;
        end
    end
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        flag_ovf,
    input logic        flag_unf,
    input logic        flag_nan
);
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flag_ovf, flag_unf, flag_nan}));

    a_r7_nan_word: assert property (@(posedge clk) disable iff (rst)
        flag_nan |-> (out_valid && result == 32'h7FC0_0000));

    a_r10_ovf_inf: assert property (@(posedge clk) disable iff (rst)
        flag_ovf |-> (out_valid && result[30:0] == 31'h7F80_0000));

    a_r11_unf_zero: assert property (@(posedge clk) disable iff (rst)
        flag_unf |-> (out_valid && result[30:0] == 31'h0));

    a_r3_sign_xor: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !flag_nan) |-> result[31] == ($past(op_a[31], 2) ^ $past(op_b[31], 2)));
endmodule

bind fp32_mul fpm_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result),
    .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_nan(flag_nan)
);

// File: tb/sim_fp32_mul.sv
`timescale 1ns/1ps
module sim_fp32_mul;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_ovf, flag_unf, flag_nan;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    fp32_mul u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result),
        .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_nan(flag_nan)
    );

    // expected flags encoded {ovf, unf, nan}
    task automatic expect_out(input logic ev, input logic [31:0] er,
                              input logic [2:0] ef, input string tag);
        checks++;
        if (out_valid !== ev || result !== er || {flag_ovf, flag_unf, flag_nan} !== ef) begin
            fails++;
            $display("FAIL %s: got v=%0b res=%08h f=%03b, expected v=%0b res=%08h f=%03b",
                     tag, out_valid, result, {flag_ovf, flag_unf, flag_nan}, ev, er, ef);
        end
    endtask

    task automatic one_vec(input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] er, input logic [2:0] ef, input string tag);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        expect_out(1'b1, er, ef, tag);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        in_valid = 1'b1; op_a = 32'h3F80_0000; op_b = 32'h3F80_0000;
        repeat (3) @(negedge clk);
        expect_out(1'b0, 32'h0, 3'b000, "R1 during reset");
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        expect_out(1'b0, 32'h0, 3'b000, "R1 after reset");
    endtask

    task automatic t_normal;
        one_vec(32'h3F00_0000, 32'hBEE0_0000, 32'hBE60_0000, 3'b000, "R3 0.5*-0.4375");
        one_vec(32'h4000_0000, 32'h4040_0000, 32'h40C0_0000, 3'b000, "R3 2*3");
        one_vec(32'hC040_0000, 32'hC080_0000, 32'h4140_0000, 3'b000, "R3 -3*-4");
        one_vec(32'h7F00_0000, 32'h3F80_0000, 32'h7F00_0000, 3'b000, "R10 top normal kept");
        one_vec(32'h0080_0000, 32'h3F80_0000, 32'h0080_0000, 3'b000, "R11 min normal kept");
    endtask

    task automatic t_normalize;
        one_vec(32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000, 3'b000, "R4 1.5*1.5");
        one_vec(32'hBFC0_0000, 32'h4000_0000, 32'hC040_0000, 3'b000, "R4 -1.5*2");
    endtask

    task automatic t_round;
        one_vec(32'h3F80_0001, 32'h3FC0_0000, 32'h3FC0_0002, 3'b000, "R5 tie odd rounds up");
        one_vec(32'h3F80_0003, 32'h3FC0_0000, 32'h3FC0_0004, 3'b000, "R5 tie even stays");
        one_vec(32'h3F80_0001, 32'h3FFF_FFFE, 32'h4000_0000, 3'b000, "R6 carry out");
    endtask

    task automatic t_special;
        one_vec(32'h7F80_0001, 32'h3F80_0000, 32'h7FC0_0000, 3'b001, "R7 nan input");
        one_vec(32'h0000_0000, 32'hFF80_0000, 32'h7FC0_0000, 3'b001, "R7 zero*inf");
        one_vec(32'h7F80_0000, 32'hC000_0000, 32'hFF80_0000, 3'b000, "R8 inf*-2");
        one_vec(32'h8000_0000, 32'h4040_0000, 32'h8000_0000, 3'b000, "R9 -0*3");
        one_vec(32'h0000_0001, 32'hBF80_0000, 32'h8000_0000, 3'b000, "R9 subnormal as zero");
    endtask

    task automatic t_range;
        one_vec(32'h7F00_0000, 32'h4000_0000, 32'h7F80_0000, 3'b100, "R10 overflow +");
        one_vec(32'hFF00_0000, 32'h4000_0000, 32'hFF80_0000, 3'b100, "R10 overflow -");
        one_vec(32'h0080_0000, 32'h3F00_0000, 32'h0000_0000, 3'b010, "R11 underflow +");
        one_vec(32'h8080_0000, 32'h3F00_0000, 32'h8000_0000, 3'b010, "R11 underflow -");
    endtask

    task automatic t_stream;
        @(negedge clk);
        op_a = 32'h4000_0000; op_b = 32'h4040_0000; in_valid = 1'b1;
        @(negedge clk);
        op_a = 32'h7F80_0001; op_b = 32'h0000_0000;
        @(negedge clk);
        op_a = 32'h3FC0_0000; op_b = 32'h3FC0_0000;
        expect_out(1'b1, 32'h40C0_0000, 3'b000, "R2 stream first");
        @(negedge clk);
        in_valid = 1'b0;
        expect_out(1'b1, 32'h7FC0_0000, 3'b001, "R2 stream second");
        @(negedge clk);
        expect_out(1'b1, 32'h4010_0000, 3'b000, "R2 stream third");
        @(negedge clk);
        expect_out(1'b0, 32'h0, 3'b000, "R2 idle after stream");
    endtask

    initial begin
        t_reset;
        t_normal;
        t_normalize;
        t_round;
        t_special;
        t_range;
        t_stream;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule